// File: doc/BRIEF.md
# Program Lock and Encrypted Read-Back Guard

This block controls access to on-chip program memory. It holds a 64-byte scramble key array and three one-way lock fuses. While code is read back for checking, it returns each code byte XNORed with a key byte. The low six address bits choose that key byte, so an unprogrammed key array, which is all ones, returns the code unchanged. It also returns fixed identification bytes when an identification read is selected.

The three lock fuses form three cumulative protection levels. The first level stops further programming. It also stops table reads issued from external code from reaching internal code, and it freezes the external-access strap at each core reset. The second level also blocks read-back. The third level also forbids execution from external memory. Any fuse pattern outside the three legal steps is treated as the third level.

The key array and the fuses are changed only by a train of 25 program pulses aimed at one unchanged target. Programming can only clear bits. A power-up reset models a fully erased part. The core reset leaves the key array and the fuses alone and only samples the strap.

Top module: `code_guard`

## Requirements
- R1: After `rst_n`, every key byte reads as FFh, all four permission outputs are 1 and `rd_data` is FFh.
- R2: With `rd_mode`=01 (read-back) and read-back allowed, `rd_data` one cycle later equals NOT(`code_in` XOR key[`addr[5:0]`]).
- R3: A key byte or a fuse is written only on the 25th consecutive rising edge of its strobe carrying the same target. The target is `addr[5:0]` plus `code_in` for the key array, and `addr[1:0]` plus `code_in` for the fuses. A different target restarts the count at 1.
- R4: A key write ANDs `code_in` into the stored byte, so bits only ever go from 1 to 0.
- R5: On `lock_pgm`, `addr[1:0]` values 1, 2 and 3 select fuses 1, 2 and 3. The value 0 selects nothing and has no effect.
- R6: With fuse 1 blown, `prog_ok` and `tbl_ext_ok` are 0 and `key_pgm` pulses are ignored.
- R7: With fuses 1 and 2 blown, `verify_ok` is 0 and a read-back returns FFh.
- R8: With all three fuses blown, `ext_exec_ok` is 0.
- R9: Any fuse pattern other than none, {1}, {1,2} or {1,2,3} gives the same outputs as all three fuses blown.
- R10: With `rd_mode`=10 (identification), `rd_data` one cycle later is 89h at address 30h, 58h at 31h, the parameter `SIG_VAR` (default C2h) at 60h, and FFh at any other address. The lock level does not affect identification reads.
- R11: At lock level 0, `ea_eff` follows `ea_pin` directly. At any higher level, `ea_eff` is the value of `ea_pin` captured on the last edge at which `core_rst` was high.
- R12: With `rd_mode` at 00 or 11 (idle), `rd_data` one cycle later is FFh.
- R13: `core_rst` changes neither the key array nor the fuses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset; erases the key array and the fuses |
| core_rst | input | 1 | Core reset; samples the external-access strap |
| addr | input | ADDR_W | Code address, also used as the programming target |
| code_in | input | 8 | Code byte from memory, also used as programming data |
| rd_mode | input | 2 | 00 idle, 01 read-back, 10 identification, 11 idle |
| key_pgm | input | 1 | Program pulse strobe for the key array |
| lock_pgm | input | 1 | Program pulse strobe for the fuses; takes priority over `key_pgm` |
| ea_pin | input | 1 | External-access strap |
| rd_data | output | 8 | Registered read-back or identification byte |
| prog_ok | output | 1 | Code programming allowed |
| tbl_ext_ok | output | 1 | Table reads from external code may fetch internal bytes |
| verify_ok | output | 1 | Read-back allowed |
| ext_exec_ok | output | 1 | Execution from external memory allowed |
| ea_eff | output | 1 | External-access value in effect |

## Verification
The properties assume that the fuses do not change during a cycle in which they judge a read-back. They also assume that `core_rst` is low whenever they judge the strap hold. The stimulus drives read requests only while both strobes are low. It pulses `core_rst` only in separate, single-cycle steps, and it programs fuses only while `rd_mode` is idle. Each strobe pulse lasts one cycle high and one cycle low, so every pulse produces exactly one rising edge.

// File: rtl/cgd_pkg.sv
package cgd_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    RD_IDLE   = 2'b00,
    RD_VERIFY = 2'b01,
    RD_SIG    = 2'b10,
    RD_RSVD   = 2'b11
  } rd_mode_e;

  typedef enum logic [1:0] {
    LVL_OPEN    = 2'd0,
    LVL_SEALED  = 2'd1,
    LVL_NOREAD  = 2'd2,
    LVL_NOEXT   = 2'd3
  } lock_lvl_e;

  localparam logic [BYTE_W-1:0] SIG_MFR = 8'h89;
  localparam logic [BYTE_W-1:0] SIG_FAM = 8'h58;

  // burnt[i] = 1 means fuse i+1 has been programmed
  function automatic lock_lvl_e level_of(input logic [2:0] burnt);
    case (burnt)
      3'b000:  return LVL_OPEN;
      3'b001:  return LVL_SEALED;
      3'b011:  return LVL_NOREAD;
      default: return LVL_NOEXT;   // 111 and all illegal patterns
    endcase
  endfunction
endpackage

// File: rtl/cgd_pulse_ctr.sv
module cgd_pulse_ctr #(
  parameter int SEL_W = 6,
  parameter int DAT_W = 8,
  parameter int NEED  = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  input  logic [DAT_W-1:0] data,
  output logic             fire
);
  localparam int CW    = $clog2(NEED + 1);
  localparam int TAG_W = SEL_W + DAT_W;

  logic             stb_q;
  logic [CW-1:0]    cnt_q, cnt_d, cnt_inc;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic             rise;

  assign rise = stb & ~stb_q & en;

  always_comb begin
    cnt_d   = cnt_q;
    tag_d   = tag_q;
    fire    = 1'b0;
    cnt_inc = CW'(1);
    if (rise) begin
      tag_d = {sel, data};
      if (cnt_q != '0 && tag_q == {sel, data}) cnt_inc = cnt_q + CW'(1);
      if (cnt_inc == CW'(NEED)) begin
        fire  = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
      cnt_q <= '0;
      tag_q <= '0;
    end else begin
      stb_q <= stb;
      cnt_q <= cnt_d;
      tag_q <= tag_d;
    end
  end
endmodule

// File: rtl/cgd_key_store.sv
module cgd_key_store #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DW-1:0]            rdata
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] key_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic hit;
    assign hit = wr && (waddr == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   key_q[i] <= '1;
      else if (hit) key_q[i] <= key_q[i] & wdata;
    end
  end

  assign rdata = key_q[raddr];
endmodule

// File: rtl/cgd_lock_bank.sv
module cgd_lock_bank
  import cgd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic [1:0] sel,
  input  logic       core_rst,
  input  logic       ea_pin,
  output lock_lvl_e  level,
  output logic       ea_eff
);
  logic [2:0] intact_q, intact_d;   // 1 = fuse unprogrammed
  logic       ea_lat_q, ea_lat_d;

  always_comb begin
    intact_d = intact_q;
    if (fire && sel != 2'd0) intact_d[sel - 2'd1] = 1'b0;
    ea_lat_d = core_rst ? ea_pin : ea_lat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intact_q <= 3'b111;
      ea_lat_q <= 1'b1;
    end else begin
      intact_q <= intact_d;
      ea_lat_q <= ea_lat_d;
    end
  end

  assign level  = level_of(~intact_q);
  assign ea_eff = (level == LVL_OPEN) ? ea_pin : ea_lat_q;
endmodule

// File: rtl/code_guard.sv
module code_guard
  import cgd_pkg::*;
#(
  parameter int              ADDR_W    = 15,
  parameter int              KEY_DEPTH = 64,
  parameter int              PULSES    = 25,
  parameter logic [7:0]      SIG_VAR   = 8'hC2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        code_in,
  input  logic [1:0]        rd_mode,
  input  logic              key_pgm,
  input  logic              lock_pgm,
  input  logic              ea_pin,
  output logic [7:0]        rd_data,
  output logic              prog_ok,
  output logic              tbl_ext_ok,
  output logic              verify_ok,
  output logic              ext_exec_ok,
  output logic              ea_eff
);
  localparam int KEY_AW = $clog2(KEY_DEPTH);

  lock_lvl_e         level;
  logic              key_fire, lock_fire, key_en;
  logic [BYTE_W-1:0] key_rd, rd_d;

  assign key_en = (level == LVL_OPEN) & ~lock_pgm;

  cgd_pulse_ctr #(.SEL_W(KEY_AW), .DAT_W(BYTE_W), .NEED(PULSES)) u_key_ctr (
    .clk(clk), .rst_n(rst_n), .stb(key_pgm), .en(key_en),
    .sel(addr[KEY_AW-1:0]), .data(code_in), .fire(key_fire));

  cgd_pulse_ctr #(.SEL_W(2), .DAT_W(BYTE_W), .NEED(PULSES)) u_lock_ctr (
    .clk(clk), .rst_n(rst_n), .stb(lock_pgm), .en(1'b1),
    .sel(addr[1:0]), .data(code_in), .fire(lock_fire));

  cgd_key_store #(.DEPTH(KEY_DEPTH), .DW(BYTE_W)) u_keys (
    .clk(clk), .rst_n(rst_n), .wr(key_fire), .waddr(addr[KEY_AW-1:0]),
    .wdata(code_in), .raddr(addr[KEY_AW-1:0]), .rdata(key_rd));

  cgd_lock_bank u_lock (
    .clk(clk), .rst_n(rst_n), .fire(lock_fire), .sel(addr[1:0]),
    .core_rst(core_rst), .ea_pin(ea_pin), .level(level), .ea_eff(ea_eff));

  assign prog_ok     = (level == LVL_OPEN);
  assign tbl_ext_ok  = (level == LVL_OPEN);
  assign verify_ok   = (level == LVL_OPEN) || (level == LVL_SEALED);
  assign ext_exec_ok = (level != LVL_NOEXT);

  always_comb begin
    rd_d = '1;
    case (rd_mode_e'(rd_mode))
      RD_VERIFY: if (verify_ok) rd_d = ~(code_in ^ key_rd);
      RD_SIG: begin
        if (addr == ADDR_W'(8'h30))      rd_d = SIG_MFR;
        else if (addr == ADDR_W'(8'h31)) rd_d = SIG_FAM;
        else if (addr == ADDR_W'(8'h60)) rd_d = SIG_VAR;
      end
      default: rd_d = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '1;
    else        rd_data <= rd_d;
  end
endmodule

// File: rtl/code_guard_chk.sv
module code_guard_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_rst,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        rd_mode,
  input logic [7:0]        rd_data,
  input logic              prog_ok,
  input logic              tbl_ext_ok,
  input logic              verify_ok,
  input logic              ext_exec_ok,
  input logic              ea_eff
);
  a_r7_verify_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode == 2'b01 && !verify_ok) |=> rd_data == 8'hFF);

  a_r10_sig_mfr: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode == 2'b10 && addr == ADDR_W'(8'h30)) |=> rd_data == 8'h89);

  a_r12_idle_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode == 2'b00 || rd_mode == 2'b11) |=> rd_data == 8'hFF);

  a_r6_prog_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_ok |=> !prog_ok);

  a_r6_tbl_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !tbl_ext_ok |=> !tbl_ext_ok);

  a_r7_cumulative: assert property (@(posedge clk) disable iff (!rst_n)
    !verify_ok |-> (!prog_ok && !tbl_ext_ok));

  a_r8_cumulative: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_exec_ok |-> !verify_ok);

  a_r11_ea_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_ok && !core_rst) |=> $stable(ea_eff));
endmodule

bind code_guard code_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_rst(core_rst), .addr(addr),
  .rd_mode(rd_mode), .rd_data(rd_data), .prog_ok(prog_ok),
  .tbl_ext_ok(tbl_ext_ok), .verify_ok(verify_ok),
  .ext_exec_ok(ext_exec_ok), .ea_eff(ea_eff));

// File: tb/sim_code_guard.sv
`timescale 1ns/1ps
module sim_code_guard;
  logic        clk = 1'b0;
  logic        rst_n, core_rst, key_pgm, lock_pgm, ea_pin;
  logic [14:0] addr;
  logic [7:0]  code_in, rd_data;
  logic [1:0]  rd_mode;
  logic        prog_ok, tbl_ext_ok, verify_ok, ext_exec_ok, ea_eff;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  code_guard u0 (
    .clk(clk), .rst_n(rst_n), .core_rst(core_rst), .addr(addr),
    .code_in(code_in), .rd_mode(rd_mode), .key_pgm(key_pgm),
    .lock_pgm(lock_pgm), .ea_pin(ea_pin), .rd_data(rd_data),
    .prog_ok(prog_ok), .tbl_ext_ok(tbl_ext_ok), .verify_ok(verify_ok),
    .ext_exec_ok(ext_exec_ok), .ea_eff(ea_eff));

  // {rd_mode, addr, code_in, expected rd_data}; key[5] = 3Ch when walked
  localparam logic [32:0] VEC [0:8] = '{
    {2'b01, 15'h0005, 8'hA5, 8'h66},
    {2'b01, 15'h0045, 8'h00, 8'hC3},
    {2'b01, 15'h0006, 8'h5A, 8'h5A},
    {2'b01, 15'h7FC5, 8'hFF, 8'h3C},
    {2'b10, 15'h0030, 8'h00, 8'h89},
    {2'b10, 15'h0031, 8'h00, 8'h58},
    {2'b10, 15'h0060, 8'h00, 8'hC2},
    {2'b10, 15'h0061, 8'h00, 8'hFF},
    {2'b00, 15'h0005, 8'hA5, 8'hFF}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input bit is_lock, input logic [14:0] a, input logic [7:0] d, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      addr = a; code_in = d;
      if (is_lock) lock_pgm = 1'b1; else key_pgm = 1'b1;
      @(negedge clk);
      lock_pgm = 1'b0; key_pgm = 1'b0;
    end
  endtask

  task automatic rd(input logic [1:0] m, input logic [14:0] a, input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    rd_mode = m; addr = a; code_in = d;
    @(negedge clk);
    q = rd_data;
    rd_mode = 2'b00;
  endtask

  task automatic power_up();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] q;
    core_rst = 0; key_pgm = 0; lock_pgm = 0; ea_pin = 1;
    addr = '0; code_in = '0; rd_mode = 2'b00;
    power_up();
    // R1 reset state
    check("R1 rd_data", rd_data, 8'hFF);
    check("R1 perms", {4'b0, prog_ok, tbl_ext_ok, verify_ok, ext_exec_ok}, 8'h0F);
    rd(2'b01, 15'h0005, 8'hA5, q); check("R1 erased key", q, 8'hA5);

    // R2/R10/R12 table walk after key[5] = 3Ch
    pulse(0, 15'h0005, 8'h3C, 25);
    for (int i = 0; i < 9; i++) begin
      logic [32:0] v;
      v = VEC[i];
      rd(v[32:31], v[30:16], v[15:8], q);
      check(v[32:31] == 2'b01 ? "R2 verify" : v[32:31] == 2'b10 ? "R10 sig" : "R12 idle", q, v[7:0]);
    end
    rd(2'b11, 15'h0005, 8'hA5, q); check("R12 mode 11", q, 8'hFF);

    // R3 pulse count
    pulse(0, 15'h0009, 8'h00, 24);
    rd(2'b01, 15'h0009, 8'h12, q); check("R3 24 pulses", q, 8'h12);
    pulse(0, 15'h0009, 8'h00, 1);
    rd(2'b01, 15'h0009, 8'h12, q); check("R3 25th pulse", q, 8'hED);
    pulse(0, 15'h000A, 8'h0F, 10);
    pulse(0, 15'h000B, 8'h0F, 1);
    pulse(0, 15'h000A, 8'h0F, 15);
    rd(2'b01, 15'h000A, 8'h77, q); check("R3 restart", q, 8'h77);

    // R4 clear-only
    pulse(0, 15'h0005, 8'hC3, 25);
    rd(2'b01, 15'h0005, 8'hA5, q); check("R4 and", q, 8'h5A);

    // R11 level 0 follows pin
    @(negedge clk); ea_pin = 1'b0; #1;
    check("R11 open follow", {7'b0, ea_eff}, 8'h00);
    ea_pin = 1'b1; #1;
    check("R11 open follow hi", {7'b0, ea_eff}, 8'h01);

    // R5 select 0 ignored; then fuse 1
    pulse(1, 15'h0000, 8'h00, 25);
    check("R5 sel0 ignored", {7'b0, prog_ok}, 8'h01);
    pulse(1, 15'h0001, 8'h00, 24);
    check("R5 24 pulses", {7'b0, prog_ok}, 8'h01);
    pulse(1, 15'h0001, 8'h00, 1);
    check("R6 level1", {4'b0, prog_ok, tbl_ext_ok, verify_ok, ext_exec_ok}, 8'h03);
    pulse(0, 15'h0006, 8'h00, 25);
    rd(2'b01, 15'h0006, 8'h5A, q); check("R6 key pgm ignored", q, 8'h5A);

    // R11 latch at core reset, R13 core reset keeps state
    @(negedge clk); ea_pin = 1'b1; core_rst = 1'b1;
    @(negedge clk); core_rst = 1'b0; ea_pin = 1'b0;
    @(negedge clk);
    check("R11 latched", {7'b0, ea_eff}, 8'h01);
    check("R13 fuses kept", {7'b0, prog_ok}, 8'h00);
    rd(2'b01, 15'h0005, 8'hA5, q); check("R13 key kept", q, 8'h5A);

    // R7 level 2
    pulse(1, 15'h0002, 8'h00, 25);
    check("R7 level2", {4'b0, prog_ok, tbl_ext_ok, verify_ok, ext_exec_ok}, 8'h01);
    rd(2'b01, 15'h0005, 8'hA5, q); check("R7 verify blocked", q, 8'hFF);
    rd(2'b10, 15'h0031, 8'h00, q); check("R10 sig under lock", q, 8'h58);

    // R8 level 3
    pulse(1, 15'h0003, 8'h00, 25);
    check("R8 level3", {4'b0, prog_ok, tbl_ext_ok, verify_ok, ext_exec_ok}, 8'h00);

    // R9 illegal pattern (fuse 2 only) after fresh power-up
    power_up();
    check("R1 re-erased", {4'b0, prog_ok, tbl_ext_ok, verify_ok, ext_exec_ok}, 8'h0F);
    pulse(1, 15'h0002, 8'h00, 25);
    check("R9 illegal as level3", {4'b0, prog_ok, tbl_ext_ok, verify_ok, ext_exec_ok}, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule